// File: doc/BRIEF.md
# CAS-before-RAS Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM alive. After reset it waits a long start-up pause. It then asks for the memory bus and runs a fixed number of wake-up refresh cycles. Only after those does it raise `ready` to tell the access controller that the memory may be used. From then on a periodic timer adds one owed refresh to a backlog each interval. While the backlog is not zero the block holds a request until the access controller grants the bus.

Every refresh is a CAS-before-RAS cycle. The block lowers CAS first, then lowers RAS, releases CAS while RAS is still low, and finally releases RAS and waits out the precharge time. Write enable is held high for the whole time, so no cycle can be taken as a write. No address is produced, because the memory's own row counter supplies the row. If the owed refreshes pile up beyond a set limit, the retention period counts as broken. The block then sets a sticky error flag, withdraws `ready` and runs the wake-up sequence again.

Every interval is a parameter counted in clock cycles. This lets a testbench shrink the pause and the refresh interval.

Top module: `cbr_refresh_seq`

## Requirements
- R1: While reset is held low, `ras_n`, `cas_n` and `we_n` are 1 and `refresh_req`, `ready`, `err` and `backlog` are 0.
- R2: `refresh_req` first goes high exactly `PAUSE_CYC` clock edges after reset is released, and no strobe moves before then.
- R3: After the pause, exactly `WAKE_CYC` refresh cycles run before `ready` goes high. `ready` rises `max(RP_CYC,RPC_CYC)` edges after the last RAS rise, with `backlog` at 0.
- R4: In every cycle RAS falls only while CAS is low, and CAS has been low for exactly `CSR_CYC` edges when RAS falls.
- R5: CAS returns high exactly `CHR_CYC` edges after RAS falls, while RAS is still low (`CHR_CYC < RAS_CYC`).
- R6: RAS stays low for exactly `RAS_CYC` edges. After RAS rises, at least `max(RP_CYC,RPC_CYC)` edges pass before CAS falls again.
- R7: `we_n` is 1 at all times.
- R8: While `ready` is high, `backlog` rises by one every `INTERVAL_CYC` edges and falls by one when a cycle ends. `refresh_req` is high exactly when `backlog` is non-zero and no cycle is in progress, and it stays high until granted.
- R9: A cycle starts, with CAS falling at the next edge, only when `refresh_req` and `grant` are both high before that edge. `grant` without a request starts nothing.
- R10: A tick that would take `backlog` past `BACKLOG_LIMIT` sets `err`, clears `backlog`, drops `ready` and repeats the `WAKE_CYC` wake-up sequence. `err` then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant | input | 1 | Bus granted to the refresh sequencer |
| refresh_req | output | 1 | Refresh wanted, held until granted |
| ready | output | 1 | Memory initialised and usable |
| err | output | 1 | Sticky: refresh backlog exceeded its limit |
| backlog | output | $clog2(BACKLOG_LIMIT+2) | Owed refresh cycles |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |

## Verification
The bench uses three grant patterns.

Grant held low while ticks build up checks the interval counting and the tie between request and backlog. A grant pulse with no request pending shows that grant alone starts nothing.

Grant held high drains the backlog in back-to-back cycles, which tests the minimum precharge gap between cycles. Grant driven at random from a seeded generator delays cycle starts by varying amounts. The count of completed cycles must still match the number of elapsed intervals.

Finally, grant is held off until the backlog overflows. This separates the normal run from the error path, in which the wake-up count must repeat and the error flag must stay set.

// File: rtl/cbr_refresh_seq.sv
module cbr_refresh_seq #(
  parameter int PAUSE_CYC     = 50000,
  parameter int INTERVAL_CYC  = 3900,
  parameter int WAKE_CYC      = 8,
  parameter int CSR_CYC       = 2,
  parameter int CHR_CYC       = 3,
  parameter int RAS_CYC       = 18,
  parameter int RP_CYC        = 13,
  parameter int RPC_CYC       = 2,
  parameter int BACKLOG_LIMIT = 6,
  localparam int BW = $clog2(BACKLOG_LIMIT + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grant,
  output logic          refresh_req,
  output logic          ready,
  output logic          err,
  output logic [BW-1:0] backlog,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n
);

  localparam int PRE_CYC = (RP_CYC > RPC_CYC) ? RP_CYC : RPC_CYC;
  localparam int MAXA    = (RAS_CYC > CSR_CYC) ? RAS_CYC : CSR_CYC;
  localparam int MAXC    = (MAXA > PRE_CYC) ? MAXA : PRE_CYC;
  localparam int CW      = $clog2(MAXC + 1);
  localparam int PW      = $clog2(PAUSE_CYC + 1);
  localparam int TW      = $clog2(INTERVAL_CYC + 1);
  localparam int WW      = $clog2(WAKE_CYC + 1);

  typedef enum logic [1:0] {M_PAUSE, M_WAKE, M_RUN} mode_t;
  typedef enum logic [1:0] {C_IDLE, C_CSR, C_LOW, C_PRE} cyc_t;

  mode_t         mode;
  cyc_t          cst;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pcnt;
  logic [TW-1:0] tcnt;
  logic [WW-1:0] wleft;
  logic          start, done, tick, over;

  assign refresh_req = (cst == C_IDLE) &&
                       (mode == M_WAKE || (mode == M_RUN && backlog != '0));
  assign start = refresh_req && grant;
  assign done  = (cst == C_PRE) && (cnt == CW'(PRE_CYC - 1));
  assign tick  = (mode == M_RUN) && (tcnt == TW'(INTERVAL_CYC - 1));
  assign over  = tick && !done && (backlog == BW'(BACKLOG_LIMIT));
  assign ready = (mode == M_RUN);
  assign we_n  = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cst   <= C_IDLE;
      cnt   <= '0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
    end else begin
      case (cst)
        C_IDLE:
          if (start) begin
            cst   <= C_CSR;
            cnt   <= '0;
            cas_n <= 1'b0;
          end
        C_CSR:
          if (cnt == CW'(CSR_CYC - 1)) begin
            cst   <= C_LOW;
            cnt   <= '0;
            ras_n <= 1'b0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        C_LOW: begin
          if (cnt == CW'(CHR_CYC - 1)) cas_n <= 1'b1;
          if (cnt == CW'(RAS_CYC - 1)) begin
            cst   <= C_PRE;
            cnt   <= '0;
            ras_n <= 1'b1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default:
          if (done) begin
            cst <= C_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= M_PAUSE;
      pcnt    <= '0;
      tcnt    <= '0;
      wleft   <= '0;
      backlog <= '0;
      err     <= 1'b0;
    end else begin
      tcnt <= (mode != M_RUN || tick) ? '0 : tcnt + TW'(1);
      case (mode)
        M_PAUSE:
          if (pcnt == PW'(PAUSE_CYC - 1)) begin
            mode  <= M_WAKE;
            wleft <= WW'(WAKE_CYC);
          end else begin
            pcnt <= pcnt + PW'(1);
          end
        M_WAKE:
          if (done) begin
            if (wleft == WW'(1)) mode <= M_RUN;
            wleft <= wleft - WW'(1);
          end
        default:
          if (over) begin
            mode    <= M_WAKE;
            wleft   <= WW'(WAKE_CYC);
            backlog <= '0;
            err     <= 1'b1;
          end else if (tick && !done) begin
            backlog <= backlog + BW'(1);
          end else if (done && !tick) begin
            backlog <= backlog - BW'(1);
          end
      endcase
    end
  end

  // R2
  pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PAUSE) |-> (ras_n && cas_n && !refresh_req));

  // R3
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (ras_n && cas_n && backlog == '0));

  // R4
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  // R5
  cas_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> !ras_n);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !grant) |=> refresh_req);

  // R9
  start_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $past(refresh_req && grant));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

// File: tb/sim_cbr_refresh_seq.sv
`timescale 1ns/1ps
module sim_cbr_refresh_seq;
  localparam int P_PAUSE = 40, P_INT = 60, P_WAKE = 8, P_CSR = 2, P_CHR = 3;
  localparam int P_RAS = 18, P_RP = 13, P_RPC = 2, P_LIM = 3;
  localparam int P_PRE = (P_RP > P_RPC) ? P_RP : P_RPC;
  localparam int BW = $clog2(P_LIM + 2);

  logic clk = 0, rst_n = 0, grant = 0;
  logic refresh_req, ready, err, ras_n, cas_n, we_n;
  logic [BW-1:0] backlog;

  always #2 clk = ~clk;

  cbr_refresh_seq #(.PAUSE_CYC(P_PAUSE), .INTERVAL_CYC(P_INT), .WAKE_CYC(P_WAKE),
    .CSR_CYC(P_CSR), .CHR_CYC(P_CHR), .RAS_CYC(P_RAS), .RP_CYC(P_RP),
    .RPC_CYC(P_RPC), .BACKLOG_LIMIT(P_LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .grant(grant), .refresh_req(refresh_req),
    .ready(ready), .err(err), .backlog(backlog), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n));

  int compared = 0, mismatched = 0;
  int ras_falls = 0, ras_rises = 0;
  int cas_since_fall = 0, ras_since_fall = 0, ras_since_rise = 0;
  bit seen_rise = 0, prev_ras = 1, prev_cas = 1, prev_req = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int exp_backlog(input int m);
    return m / P_INT;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      cas_since_fall++; ras_since_fall++; ras_since_rise++;
      if (!cas_n && prev_cas) begin
        chk(grant && prev_req, "R9 start needs req and grant", int'(grant && prev_req), 1);
        if (seen_rise) chk(ras_since_rise >= P_PRE, "R6 precharge gap", ras_since_rise, P_PRE);
        cas_since_fall = 0;
      end
      if (!ras_n && prev_ras) begin
        chk(!cas_n, "R4 CAS low at RAS fall", int'(cas_n), 0);
        chk(cas_since_fall == P_CSR, "R4 CAS lead", cas_since_fall, P_CSR);
        ras_since_fall = 0;
        ras_falls++;
      end
      if (cas_n && !prev_cas)
        chk(!ras_n && ras_since_fall == P_CHR, "R5 CAS hold", ras_since_fall, P_CHR);
      if (ras_n && !prev_ras) begin
        chk(ras_since_fall == P_RAS, "R6 RAS width", ras_since_fall, P_RAS);
        ras_since_rise = 0;
        seen_rise = 1;
        ras_rises++;
      end
      if (!we_n) chk(0, "R7 we_n high", int'(we_n), 1);
    end
    prev_ras = ras_n; prev_cas = cas_n; prev_req = refresh_req;
  end

  task automatic step;
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog all-R actual=running expected=finished");
    finish_run();
  end

  initial begin
    int mrun, m0, rf0, rr0, i;
    void'($urandom(32'h5eed));
    repeat (5) step();
    chk(ras_n && cas_n && we_n, "R1 strobes idle in reset", {ras_n, cas_n, we_n}, 7);
    chk(!refresh_req && !ready, "R1 req/ready low in reset", {refresh_req, ready}, 0);
    chk(!err && backlog == 0, "R1 err/backlog clear in reset", int'(backlog), 0);

    @(negedge clk); rst_n = 1;
    for (i = 1; i < 500; i++) begin
      step();
      if (refresh_req) break;
    end
    chk(i == P_PAUSE, "R2 pause length", i, P_PAUSE);
    chk(ras_falls == 0, "R2 no strobes during pause", ras_falls, 0);

    for (int k = 0; k < 3000; k++) begin
      step();
      if (ready) break;
      grant = 1'($urandom % 2);
    end
    grant = 0;
    chk(ready == 1, "R3 ready after wake-up", int'(ready), 1);
    chk(ras_falls == P_WAKE, "R3 wake-up count", ras_falls, P_WAKE);
    chk(ras_since_rise == P_PRE, "R3 ready after last precharge", ras_since_rise, P_PRE);
    chk(backlog == 0, "R3 backlog zero at ready", int'(backlog), 0);

    mrun = 0; rr0 = ras_rises; rf0 = ras_falls;
    grant = 1;
    for (int m = 1; m <= 2 * P_INT + 10; m++) begin
      step(); mrun++;
      grant = (m + 1 < P_INT);
      chk(int'(backlog) == exp_backlog(mrun), "R8 backlog count", int'(backlog), exp_backlog(mrun));
      chk(refresh_req == (exp_backlog(mrun) != 0), "R8 req follows backlog", int'(refresh_req), int'(exp_backlog(mrun) != 0));
      if (m == P_INT - 1) chk(ras_falls == rf0, "R9 grant alone starts nothing", ras_falls, rf0);
    end

    grant = 1;
    for (int k = 0; k < 400 && backlog != 0; k++) begin step(); mrun++; end
    chk(ras_rises - rr0 == exp_backlog(mrun), "R8 drain completions", ras_rises - rr0, exp_backlog(mrun));
    chk(ready && !err, "R8 stays ready while draining", int'(ready && !err), 1);

    for (int k = 0; k < 2500; k++) begin
      step(); mrun++;
      grant = ($urandom % 3) != 0;
    end
    grant = 1;
    for (int k = 0; k < 400 && backlog != 0; k++) begin step(); mrun++; end
    chk(backlog == 0, "R8 random phase drained", int'(backlog), 0);
    chk(ras_rises - rr0 == exp_backlog(mrun), "R8 random completions", ras_rises - rr0, exp_backlog(mrun));
    chk(!err && ready, "R10 no error at normal rate", int'(err), 0);

    grant = 0; m0 = mrun;
    for (int k = 0; k < 600; k++) begin
      int t;
      step(); mrun++;
      t = exp_backlog(mrun) - exp_backlog(m0);
      chk(err == (t >= P_LIM + 1), "R10 error timing", int'(err), int'(t >= P_LIM + 1));
      if (err) break;
    end
    chk(!ready && backlog == 0 && refresh_req, "R10 rewake entered",
        {ready, refresh_req}, 1);
    rf0 = ras_falls;
    for (int k = 0; k < 3000; k++) begin
      step();
      if (ready) break;
      grant = 1'($urandom % 2);
    end
    grant = 0;
    chk(ras_falls - rf0 == P_WAKE, "R10 rewake count", ras_falls - rf0, P_WAKE);
    chk(err == 1, "R10 err sticky", int'(err), 1);

    rst_n = 0;
    repeat (3) step();
    chk(!err && !ready, "R1 reset clears err", {err, ready}, 0);
    finish_run();
  end
endmodule